// File: doc/BRIEF.md
# Compute Job Front-End

This block sits in front of a compute engine and turns register writes into a stream of batch dispatch requests. Software fills a staging set of seven 32-bit configuration words over a plain register bus. Writing the last word starts the job. If the engine is idle, the staged words are copied into a separate, readable active set one cycle later. The block then offers one request per batch to a worker over a valid/ready handshake.

Each request carries the decoded job fields: workgroup counts, workgroup sizing, the code address with its mode flags split out, the uniforms address and the batch index. A second job can wait in the staging set while the first one runs. It is promoted as soon as the running job retires. When a job ends, the block sets a sticky interrupt bit, and software clears that bit by writing 1 to it.

Top module: `wgjob_frontend`

## Requirements
- R1: After reset, the status word (offset 0x900) reads 0, `disp_valid` is low and `irq` is low.
- R2: Writing offset 0x904 + 4*k (k = 0..6) stores staging word k, and a read at the same offset returns it. Writing k = 6 (offset 0x91C) starts the job.
- R3: If no job is active when the job is started, the seven staging words appear in the active set (offsets 0x920 + 4*k) on the next cycle. Status bit 0 (busy) then reads 1 and status bit 1 (queued) reads 0.
- R4: If a job is active when the job is started, the new job stays staged with status bit 1 set. It is promoted in the cycle after the active job retires.
- R5: While a job is staged, any write to the staging offsets is ignored. A write to 0x91C at that time also sets the sticky error bit (status bit 2), which writing 1 to status bit 2 clears.
- R6: A job issues active word 4 + 1 requests, with `disp_batch` counting 0, 1, ... upward. The index advances only on a cycle with `disp_valid` and `disp_ready` both high. While `disp_ready` is low, `disp_valid` and `disp_batch` hold.
- R7: In the cycle after the last handshake, busy drops and the sticky interrupt (status bit 3, mirrored on `irq`) rises. Writing 1 to status bit 3 clears it. A set in the same cycle wins over a clear.
- R8: `disp_code_addr` is active word 5 with bits 2:0 forced to 0. The flags come from word 5: bit 0 drives `disp_threaded`, bit 1 drives `disp_single_seg` and bit 2 drives `disp_nan_prop`.
- R9: `disp_unif_addr` is active word 6 with bits 1:0 forced to 0. `disp_wg_x/y/z` are bits 31:16 of active words 0/1/2. From word 3, `disp_wg_size` takes bits 7:0, `disp_wgs_per_sg` takes bits 11:8 and `disp_sg_lines_m1` takes bits 31:12.
- R10: Status bits 31:16 count the handshakes of the current job. The count is cleared when a job is promoted and holds after the job retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| disp_valid | output | 1 | Batch request valid |
| disp_ready | input | 1 | Worker accepts request |
| disp_batch | output | 16 | Batch index |
| disp_code_addr | output | 32 | Code address, flags cleared |
| disp_threaded | output | 1 | Four-way threading flag |
| disp_single_seg | output | 1 | Single-segment flag |
| disp_nan_prop | output | 1 | NaN propagation flag |
| disp_unif_addr | output | 32 | Uniforms address, word aligned |
| disp_wg_x | output | 16 | Workgroup count X |
| disp_wg_y | output | 16 | Workgroup count Y |
| disp_wg_z | output | 16 | Workgroup count Z |
| disp_wg_size | output | 8 | Workgroup size |
| disp_wgs_per_sg | output | 4 | Workgroups per supergroup |
| disp_sg_lines_m1 | output | 20 | Rounded supergroup size minus one |
| irq | output | 1 | Sticky job-complete interrupt |

## Verification
The bench builds the block with its default batch width of 16. That keeps the full status count field in use and lets jobs of one, two and three batches be written directly into word 4. The worker's ready input is driven in three patterns: always high, alternating and held low. Held-low ready keeps a job running long enough to stage a second job and to collide a further start with the staged one. Every cycle, the reference model's view of the register at the current bus offset and of the dispatch outputs is compared against the design.

// File: rtl/wgjob_pkg.sv
package wgjob_pkg;
  localparam int NCFG = 7;
  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] STATUS_OFF  = 12'h900;
  localparam logic [ADDR_W-1:0] STAGE_OFF   = 12'h904;
  localparam logic [ADDR_W-1:0] ACTIVE_OFF  = 12'h920;
  localparam int KICK_IDX = 6;

  typedef logic [31:0] word_t;

  typedef struct packed {
    logic nan_prop;
    logic single_seg;
    logic threaded;
  } mode_t;

  function automatic word_t f_code_addr(word_t w);
    return {w[31:3], 3'b000};
  endfunction

  function automatic mode_t f_mode(word_t w);
    return mode_t'(w[2:0]);
  endfunction

  function automatic word_t f_unif_addr(word_t w);
    return {w[31:2], 2'b00};
  endfunction

  function automatic logic [15:0] f_wg_count(word_t w);
    return w[31:16];
  endfunction
endpackage

// File: rtl/wgjob_regs.sv
module wgjob_regs
  import wgjob_pkg::*;
#(
  parameter int BATCH_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  word_t                      wdata_i,
  output word_t                      rdata_o,
  input  logic                       busy_i,
  input  logic                       done_i,
  input  logic [BATCH_W-1:0]         cnt_i,
  output logic                       promote_o,
  output word_t [NCFG-1:0]           active_o,
  output logic                       irq_o
);
  word_t [NCFG-1:0] stage_q;
  word_t [NCFG-1:0] active_q;
  logic [NCFG-1:0]  stage_hit;
  logic [NCFG-1:0]  active_hit;
  logic             pending_q, err_q, irq_q;
  logic             status_wr, kick_ok, kick_clash;

  genvar k;
  generate
    for (k = 0; k < NCFG; k++) begin : g_word
      assign stage_hit[k]  = (addr_i == STAGE_OFF  + ADDR_W'(4 * k));
      assign active_hit[k] = (addr_i == ACTIVE_OFF + ADDR_W'(4 * k));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[k]  <= '0;
          active_q[k] <= '0;
        end else begin
          if (wr_i && stage_hit[k] && !pending_q) stage_q[k] <= wdata_i;
          if (promote_o) active_q[k] <= stage_q[k];
        end
      end
    end
  endgenerate

  assign kick_ok    = wr_i && stage_hit[KICK_IDX] && !pending_q;
  assign kick_clash = wr_i && stage_hit[KICK_IDX] && pending_q;
  assign promote_o  = pending_q && !busy_i;
  assign status_wr  = wr_i && (addr_i == STATUS_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      err_q     <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (promote_o)    pending_q <= 1'b0;
      else if (kick_ok) pending_q <= 1'b1;
      err_q <= (err_q & ~(status_wr & wdata_i[2])) | kick_clash;
      irq_q <= (irq_q & ~(status_wr & wdata_i[3])) | done_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == STATUS_OFF)
      rdata_o = {16'(cnt_i), 12'd0, irq_q, err_q, pending_q, busy_i};
    for (int i = 0; i < NCFG; i++) begin
      if (stage_hit[i])  rdata_o = stage_q[i];
      if (active_hit[i]) rdata_o = active_q[i];
    end
  end

  assign active_o = active_q;
  assign irq_o    = irq_q;

  p_promote_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    promote_o |=> busy_i);
  p_clash_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    kick_clash |=> err_q);
  p_done_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> irq_q);
endmodule

// File: rtl/wgjob_seq.sv
module wgjob_seq #(
  parameter int BATCH_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [BATCH_W-1:0] last_i,
  input  logic               ready_i,
  output logic               valid_o,
  output logic [BATCH_W-1:0] batch_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [BATCH_W-1:0] cnt_o
);
  logic               busy_q;
  logic [BATCH_W-1:0] idx_q, cnt_q;
  logic               hs;

  assign hs     = busy_q && ready_i;
  assign done_o = hs && (idx_q == last_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else if (hs) begin
      cnt_q <= cnt_q + 1'b1;
      if (done_o) busy_q <= 1'b0;
      else        idx_q  <= idx_q + 1'b1;
    end
  end

  assign valid_o = busy_q;
  assign batch_o = idx_q;
  assign busy_o  = busy_q;
  assign cnt_o   = cnt_q;

  p_hold_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(batch_o)));
  p_index_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (idx_q <= last_i));
endmodule

// File: rtl/wgjob_frontend.sv
module wgjob_frontend
  import wgjob_pkg::*;
#(
  parameter int BATCH_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [11:0]        reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               disp_valid,
  input  logic               disp_ready,
  output logic [BATCH_W-1:0] disp_batch,
  output logic [31:0]        disp_code_addr,
  output logic               disp_threaded,
  output logic               disp_single_seg,
  output logic               disp_nan_prop,
  output logic [31:0]        disp_unif_addr,
  output logic [15:0]        disp_wg_x,
  output logic [15:0]        disp_wg_y,
  output logic [15:0]        disp_wg_z,
  output logic [7:0]         disp_wg_size,
  output logic [3:0]         disp_wgs_per_sg,
  output logic [19:0]        disp_sg_lines_m1,
  output logic               irq
);
  word_t [NCFG-1:0]   active;
  logic               promote, busy, done;
  logic [BATCH_W-1:0] cnt;
  mode_t              mode;

  wgjob_regs #(.BATCH_W(BATCH_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .rdata_o(reg_rdata), .busy_i(busy),
    .done_i(done), .cnt_i(cnt), .promote_o(promote),
    .active_o(active), .irq_o(irq)
  );

  wgjob_seq #(.BATCH_W(BATCH_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(promote),
    .last_i(active[4][BATCH_W-1:0]), .ready_i(disp_ready),
    .valid_o(disp_valid), .batch_o(disp_batch), .busy_o(busy),
    .done_o(done), .cnt_o(cnt)
  );

  assign mode             = f_mode(active[5]);
  assign disp_code_addr   = f_code_addr(active[5]);
  assign disp_threaded    = mode.threaded;
  assign disp_single_seg  = mode.single_seg;
  assign disp_nan_prop    = mode.nan_prop;
  assign disp_unif_addr   = f_unif_addr(active[6]);
  assign disp_wg_x        = f_wg_count(active[0]);
  assign disp_wg_y        = f_wg_count(active[1]);
  assign disp_wg_z        = f_wg_count(active[2]);
  assign disp_wg_size     = active[3][7:0];
  assign disp_wgs_per_sg  = active[3][11:8];
  assign disp_sg_lines_m1 = active[3][31:12];
endmodule

// File: tb/wgjob_frontend_bench.sv
module wgjob_frontend_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = 12'h900;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        disp_valid, disp_ready;
  logic [15:0] disp_batch;
  logic [31:0] disp_code_addr, disp_unif_addr;
  logic        disp_threaded, disp_single_seg, disp_nan_prop;
  logic [15:0] disp_wg_x, disp_wg_y, disp_wg_z;
  logic [7:0]  disp_wg_size;
  logic [3:0]  disp_wgs_per_sg;
  logic [19:0] disp_sg_lines_m1;
  logic        irq;

  int checks = 0;
  int fails = 0;
  int rdy_mode = 0;
  logic rdy_tog = 1'b0;

  // reference model state
  logic [31:0] m_q [7];
  logic [31:0] m_c [7];
  int  m_idx = 0, m_cnt = 0;
  bit  m_busy = 0, m_pend = 0, m_err = 0, m_irq = 0;

  always #4 clk = ~clk;

  wgjob_frontend u_wgjob_frontend (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .disp_valid(disp_valid),
    .disp_ready(disp_ready), .disp_batch(disp_batch),
    .disp_code_addr(disp_code_addr), .disp_threaded(disp_threaded),
    .disp_single_seg(disp_single_seg), .disp_nan_prop(disp_nan_prop),
    .disp_unif_addr(disp_unif_addr), .disp_wg_x(disp_wg_x),
    .disp_wg_y(disp_wg_y), .disp_wg_z(disp_wg_z), .disp_wg_size(disp_wg_size),
    .disp_wgs_per_sg(disp_wgs_per_sg), .disp_sg_lines_m1(disp_sg_lines_m1),
    .irq(irq)
  );

  assign disp_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? rdy_tog : 1'b0;
  always @(negedge clk) rdy_tog <= ~rdy_tog;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] mread(logic [11:0] a);
    if (a == 12'h900)
      return {m_cnt[15:0], 12'd0, m_irq, m_err, m_pend, m_busy};
    for (int k = 0; k < 7; k++) begin
      if (a == 12'h904 + 12'(4 * k)) return m_q[k];
      if (a == 12'h920 + 12'(4 * k)) return m_c[k];
    end
    return 32'd0;
  endfunction

  initial begin
    for (int k = 0; k < 7; k++) begin m_q[k] = '0; m_c[k] = '0; end
  end

  // behavioural model, updated from pre-edge state and stable inputs
  always @(posedge clk) begin
    if (rst_n) begin
      bit promote, hs;
      promote = m_pend && !m_busy;
      hs = m_busy && disp_ready;
      if (reg_wr && reg_addr == 12'h900) begin
        if (reg_wdata[2]) m_err = 0;
        if (reg_wdata[3]) m_irq = 0;
      end
      if (reg_wr && reg_addr >= 12'h904 && reg_addr <= 12'h91C && reg_addr[1:0] == 0) begin
        int k;
        k = (int'(reg_addr) - 'h904) / 4;
        if (promote || m_pend) begin
          if (k == 6) m_err = 1;
        end else begin
          m_q[k] = reg_wdata;
        end
      end
      if (hs) begin
        m_cnt++;
        if (m_idx == int'(m_c[4][15:0])) begin m_busy = 0; m_irq = 1; end
        else m_idx++;
      end
      if (promote) begin
        for (int k = 0; k < 7; k++) m_c[k] = m_q[k];
        m_busy = 1; m_idx = 0; m_cnt = 0; m_pend = 0;
      end else if (reg_wr && reg_addr == 12'h91C && !m_pend) begin
        m_pend = 1;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      string tg;
      tg = (reg_addr == 12'h900) ? "R10 status" :
           (reg_addr >= 12'h920) ? "R3 active word" : "R2 staged word";
      chk(tg, reg_rdata, mread(reg_addr));
      chk("R6 valid", {31'd0, disp_valid}, {31'd0, m_busy});
      chk("R7 irq", {31'd0, irq}, {31'd0, m_irq});
      if (m_busy) begin
        chk("R6 batch", {16'd0, disp_batch}, 32'(m_idx));
        chk("R8 code addr", disp_code_addr, m_c[5] - (m_c[5] % 8));
        chk("R8 flags", {29'd0, disp_nan_prop, disp_single_seg, disp_threaded},
            m_c[5] % 8);
        chk("R9 uniforms", disp_unif_addr, (m_c[6] / 4) * 4);
        chk("R9 wg x", {16'd0, disp_wg_x}, m_c[0] / 65536);
        chk("R9 wg y", {16'd0, disp_wg_y}, m_c[1] / 65536);
        chk("R9 wg z", {16'd0, disp_wg_z}, m_c[2] / 65536);
        chk("R9 sizing", {disp_sg_lines_m1, disp_wgs_per_sg, disp_wg_size}, m_c[3]);
      end
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 12'h900; reg_wdata = '0;
  endtask

  task automatic rd(logic [11:0] a, string tag, logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #3;
    chk(tag, reg_rdata, exp);
    @(negedge clk);
    reg_addr = 12'h900;
  endtask

  task automatic load(logic [31:0] w0, logic [31:0] w3, logic [31:0] nb_m1,
                      logic [31:0] w5, logic [31:0] w6);
    wr(12'h904, w0);
    wr(12'h908, w0 + 32'h0001_0000);
    wr(12'h90C, w0 + 32'h0002_0000);
    wr(12'h910, w3);
    wr(12'h914, nb_m1);
    wr(12'h918, w5);
    wr(12'h91C, w6);
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && (m_busy || m_pend); i++) @(negedge clk);
  endtask

  initial begin
    #20000000;
    fails++;
    $display("FAIL watchdog: got hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #3;
    chk("R1 reset status", reg_rdata, 32'd0);
    chk("R1 reset valid", {31'd0, disp_valid}, 32'd0);
    chk("R1 reset irq", {31'd0, irq}, 32'd0);

    // job A: three batches, ready always high
    rdy_mode = 0;
    wr(12'h904, 32'h0004_0000);
    rd(12'h904, "R2 readback word0", 32'h0004_0000);
    load(32'h0004_0000, 32'h0003_F208, 32'd2, 32'h0001_2340, 32'h0000_8000);
    rd(12'h920, "R3 active word0", 32'h0004_0000);
    drain();
    rd(12'h900, "R10 count after three", 32'h0003_0008);
    chk("R7 irq after job", {31'd0, irq}, 32'd1);
    wr(12'h900, 32'h0000_0008);
    chk("R7 irq cleared", {31'd0, irq}, 32'd0);

    // job B: one batch, alternating ready, all flags, unaligned uniforms
    rdy_mode = 1;
    load(32'h0010_0000, 32'h0000_0140, 32'd0, 32'h0005_0007, 32'h0001_0003);
    @(negedge clk); #3;
    chk("R8 flags all set", {29'd0, disp_nan_prop, disp_single_seg, disp_threaded}, 32'd7);
    chk("R9 uniforms aligned", disp_unif_addr, 32'h0001_0000);
    drain();
    rd(12'h900, "R6 single batch", 32'h0001_0008);
    wr(12'h900, 32'h0000_0008);

    // job C held by low ready, job D staged behind it, extra kick collides
    rdy_mode = 2;
    load(32'h0020_0000, 32'h0001_0101, 32'd1, 32'h0000_4002, 32'h0000_0400);
    load(32'h0030_0000, 32'h0002_0202, 32'd1, 32'h0000_8004, 32'h0000_0800);
    rd(12'h900, "R4 queued bit", 32'h0000_0003);
    wr(12'h904, 32'hDEAD_0000);
    rd(12'h904, "R5 staged word unchanged", 32'h0030_0000);
    wr(12'h91C, 32'h0000_0C00);
    rd(12'h900, "R5 error set", 32'h0000_0007);
    chk("R6 stall valid", {31'd0, disp_valid}, 32'd1);
    wr(12'h900, 32'h0000_0004);
    rd(12'h900, "R5 error cleared", 32'h0000_0003);
    rdy_mode = 0;
    drain();
    rd(12'h920, "R4 job D promoted", 32'h0030_0000);
    rd(12'h900, "R10 count job D", 32'h0002_0008);

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule